// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register

This block takes command words from a host controller over three slow wires: a strobe, a shift clock and a data line. Each word is 13 bits long. The leading bits of the word select the register bank that the word writes, so the word carries its own address. Bits arrive first-bit-first, and the block samples each one on a rising edge of the shift clock. A rising edge on the strobe commits the assembled word into the chosen bank, but only when exactly 13 bits were shifted since the previous strobe edge.

All three wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edge detection works only on the synchronized copies. The host holds the strobe low while it shifts and must leave a gap of several system clocks between the final shift edge and the strobe rise. The decoded settings are plain register outputs for the datapath that follows: a 12-bit level code, six output-format and compressor flags, and six bass-boost control flags.

Top module: `ser_cfg_port`

## Requirements
- R1: Out of reset, every output register is zero.
- R2: Bits are sampled on rising shift-clock edges. The first bit shifted is word bit 0 and the thirteenth is word bit 12. The shift register does not change on any cycle without a synchronized shift-clock rise.
- R3: A committed word with bit 12 = 0 loads bits 11..0 into the level output, with bit 11 as its MSB. The other twelve outputs are left unchanged.
- R4: A committed word with bit 12 = 1 and bit 11 = 0 loads bits 10..5 into de-emphasis, mono, channel select, frame-polarity, deep-compression and dynamic-off, in that order. Bits 4..0 are ignored, and the level and bass-boost outputs are left unchanged.
- R5: A committed word with bit 12 = 1 and bit 11 = 1 loads bits 10..5 into boost bit 1, boost bit 2, boost bit 3, boost mute, slow attack and slow recovery, in that order. The level and format outputs are left unchanged.
- R6: Outputs change only on a commit. Shifting a complete word leaves them unchanged until the strobe rises, and the new values appear within eight system clocks of that rise.
- R7: A strobe rise after fewer or more than 13 shifted bits changes no output. Every strobe rise clears the bit counter, so the next well-formed word commits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_strobe | input | 1 | Commit strobe; held low while shifting, rising edge commits |
| ctl_sclk | input | 1 | Shift clock; data sampled on its rising edge |
| ctl_sdat | input | 1 | Serial data, first bit is word bit 0 |
| level_code | output | 12 | Output level code |
| deemph_en | output | 1 | De-emphasis enable |
| mono_en | output | 1 | 0 = stereo; 1 = mono from the channel picked by chan_sel |
| chan_sel | output | 1 | In mono: 0 = left channel, 1 = right channel |
| frame_pol | output | 1 | 0 = right data while frame clock is low; 1 = left data while it is low |
| comp_deep | output | 1 | Deeper compression characteristic select |
| dyn_off | output | 1 | Dynamic compressor disable |
| boost_b1 | output | 1 | Bass-boost mode bit 1 |
| boost_b2 | output | 1 | Bass-boost mode bit 2 |
| boost_b3 | output | 1 | Bass-boost mode bit 3 (extended range) |
| boost_mute | output | 1 | Bass-boost mute |
| attack_slow | output | 1 | Long attack time select |
| release_slow | output | 1 | Long recovery time select |

## Verification
The assertions assume that the host never changes the shift clock and the strobe within the same few system clocks. A shift-clock rise and a strobe rise that land on the same synchronized cycle would see the strobe win. The stimulus therefore holds every wire level for four system clocks, and it waits four clocks after the last shift edge before it raises the strobe. The random phase mixes well-formed words with 12-bit and 14-bit ones and draws all three bank selectors. Directed cases cover bit order, the hold before commit and counter recovery after a malformed word.

// File: rtl/ser_cfg_pkg.sv
// Shared constants and register-bank types for the serial configuration port.
// Assumes a word carries its bank selector in its two top bits.
package ser_cfg_pkg;
    localparam int WORD_BITS  = 13;
    localparam int LEVEL_BITS = 12;

    // Format/compressor flags, MSB loaded from the highest flag bit of the word
    typedef struct packed {
        logic deemph;
        logic mono;
        logic chan;
        logic fpol;
        logic deep;
        logic dynoff;
    } fmt_bank_t;

    // Bass-boost flags, same placement in the word as fmt_bank_t
    typedef struct packed {
        logic b1;
        logic b2;
        logic b3;
        logic mute;
        logic atk;
        logic rel;
    } boost_bank_t;
endpackage

// File: rtl/ser_cfg_sync.sv
// Multi-stage synchronizer for a group of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherence is implied.
module ser_cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Move the sampled inputs one stage further along the chain each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ser_cfg_shifter.sv
// Edge detection, serial shift register and bit counter.
// Assumes synchronized inputs; a strobe rise wins over a coincident shift rise.
// Produces a one-cycle commit pulse only when exactly WORD_BITS bits were shifted.
module ser_cfg_shifter #(
    parameter int WORD_BITS = ser_cfg_pkg::WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 strobe_s,
    input  logic                 sdat_s,
    output logic [WORD_BITS-1:0] word,
    output logic                 commit
);
    localparam int CNT_MAX = WORD_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             sclk_d, strobe_d;
    logic [CNT_W-1:0] bit_cnt;
    logic             sclk_rise, strobe_rise;

    // Derive single-cycle rising-edge pulses from the synchronized levels
    assign sclk_rise   = sclk_s & ~sclk_d;
    assign strobe_rise = strobe_s & ~strobe_d;

    // Hold previous levels, shift data in at the top, count bits with saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            strobe_d <= 1'b0;
            bit_cnt  <= '0;
            word     <= '0;
        end else begin
            sclk_d   <= sclk_s;
            strobe_d <= strobe_s;
            if (strobe_rise) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                word <= {sdat_s, word[WORD_BITS-1:1]};
                if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Commit only for a word of exactly the expected length
    assign commit = strobe_rise && (bit_cnt == CNT_W'(WORD_BITS));

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> bit_cnt == '0);

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(word));

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/ser_cfg_bank.sv
// Decodes a committed word by its top two bits and loads one register bank.
// Assumes commit is a single-cycle pulse and word is stable during it.
module ser_cfg_bank #(
    parameter int WORD_BITS  = ser_cfg_pkg::WORD_BITS,
    parameter int LEVEL_BITS = ser_cfg_pkg::LEVEL_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [WORD_BITS-1:0]         word,
    output logic [LEVEL_BITS-1:0]        level_q,
    output ser_cfg_pkg::fmt_bank_t       fmt_q,
    output ser_cfg_pkg::boost_bank_t     boost_q
);
    import ser_cfg_pkg::*;

    localparam int SEL_HI  = WORD_BITS - 1;
    localparam int SEL_LO  = WORD_BITS - 2;
    localparam int FLG_N   = $bits(fmt_bank_t);
    localparam int FLG_HI  = WORD_BITS - 3;
    localparam int FLG_LO  = FLG_HI - FLG_N + 1;

    logic is_level, is_fmt, is_boost;

    // Bank select from the leading bits of the word
    always_comb begin
        is_level = commit && !word[SEL_HI];
        is_fmt   = commit &&  word[SEL_HI] && !word[SEL_LO];
        is_boost = commit &&  word[SEL_HI] &&  word[SEL_LO];
    end

    // Load the selected bank and leave the others untouched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            fmt_q   <= '0;
            boost_q <= '0;
        end else begin
            if (is_level) level_q <= word[LEVEL_BITS-1:0];
            if (is_fmt)   fmt_q   <= fmt_bank_t'(word[FLG_HI:FLG_LO]);
            if (is_boost) boost_q <= boost_bank_t'(word[FLG_HI:FLG_LO]);
        end
    end

    // R6
    no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(level_q) && $stable(fmt_q) && $stable(boost_q));

    // R3
    level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !word[SEL_HI]) |=>
            level_q == $past(word[LEVEL_BITS-1:0]) && $stable(fmt_q) && $stable(boost_q));

    // R4
    fmt_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[SEL_HI] && !word[SEL_LO]) |=> $stable(level_q) && $stable(boost_q));

    // R5
    boost_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[SEL_HI] && word[SEL_LO]) |=> $stable(level_q) && $stable(fmt_q));

    // R3
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_level, is_fmt, is_boost}));
endmodule

// File: rtl/ser_cfg_port.sv
// Top of the three-wire serial configuration port: synchronizer, shifter, banks.
// Assumes the host keeps the strobe low while shifting and leaves a gap of
// several system clocks between the last shift edge and the strobe rise.
module ser_cfg_port #(
    parameter int WORD_BITS   = ser_cfg_pkg::WORD_BITS,
    parameter int LEVEL_BITS  = ser_cfg_pkg::LEVEL_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_strobe,
    input  logic                  ctl_sclk,
    input  logic                  ctl_sdat,
    output logic [LEVEL_BITS-1:0] level_code,
    output logic                  deemph_en,
    output logic                  mono_en,
    output logic                  chan_sel,
    output logic                  frame_pol,
    output logic                  comp_deep,
    output logic                  dyn_off,
    output logic                  boost_b1,
    output logic                  boost_b2,
    output logic                  boost_b3,
    output logic                  boost_mute,
    output logic                  attack_slow,
    output logic                  release_slow
);
    import ser_cfg_pkg::*;

    logic [2:0]           pins_s;
    logic [WORD_BITS-1:0] word;
    logic                 commit;
    fmt_bank_t            fmt_q;
    boost_bank_t          boost_q;

    ser_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ctl_strobe, ctl_sclk, ctl_sdat}),
        .sync_out (pins_s)
    );

    ser_cfg_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[1]),
        .strobe_s (pins_s[2]),
        .sdat_s   (pins_s[0]),
        .word     (word),
        .commit   (commit)
    );

    ser_cfg_bank #(.WORD_BITS(WORD_BITS), .LEVEL_BITS(LEVEL_BITS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .word    (word),
        .level_q (level_code),
        .fmt_q   (fmt_q),
        .boost_q (boost_q)
    );

    // Fan the bank structs out to named ports
    always_comb begin
        deemph_en    = fmt_q.deemph;
        mono_en      = fmt_q.mono;
        chan_sel     = fmt_q.chan;
        frame_pol    = fmt_q.fpol;
        comp_deep    = fmt_q.deep;
        dyn_off      = fmt_q.dynoff;
        boost_b1     = boost_q.b1;
        boost_b2     = boost_q.b2;
        boost_b3     = boost_q.b3;
        boost_mute   = boost_q.mute;
        attack_slow  = boost_q.atk;
        release_slow = boost_q.rel;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> level_code == '0 && fmt_q == '0 && boost_q == '0);
endmodule

// File: tb/ser_cfg_port_test.sv
module ser_cfg_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_strobe = 1'b0, ctl_sclk = 1'b0, ctl_sdat = 1'b0;
    logic [11:0] level_code;
    logic deemph_en, mono_en, chan_sel, frame_pol, comp_deep, dyn_off;
    logic boost_b1, boost_b2, boost_b3, boost_mute, attack_slow, release_slow;

    int n_checks = 0;
    int n_fail   = 0;
    logic [23:0] exp_st = '0;

    always #5 clk = ~clk;

    ser_cfg_port uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_strobe(ctl_strobe), .ctl_sclk(ctl_sclk), .ctl_sdat(ctl_sdat),
        .level_code(level_code), .deemph_en(deemph_en), .mono_en(mono_en),
        .chan_sel(chan_sel), .frame_pol(frame_pol), .comp_deep(comp_deep),
        .dyn_off(dyn_off), .boost_b1(boost_b1), .boost_b2(boost_b2),
        .boost_b3(boost_b3), .boost_mute(boost_mute),
        .attack_slow(attack_slow), .release_slow(release_slow)
    );

    function automatic logic [23:0] outs();
        return {level_code, deemph_en, mono_en, chan_sel, frame_pol, comp_deep, dyn_off,
                boost_b1, boost_b2, boost_b3, boost_mute, attack_slow, release_slow};
    endfunction

    // Expected state after a well-formed word, from R3, R4, R5
    function automatic logic [23:0] model(logic [23:0] st, logic [12:0] w);
        logic [23:0] r = st;
        if (!w[12])     r[23:12] = w[11:0];
        else if (!w[11]) r[11:6] = w[10:5];
        else             r[5:0]  = w[10:5];
        return r;
    endfunction

    task automatic check(string req, logic [23:0] exp_v);
        n_checks++;
        if (outs() !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, outs(), exp_v);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift nbits (bit 0 first), optionally raise the strobe afterwards
    task automatic shift_word(logic [15:0] w, int nbits, bit do_strobe);
        ctl_strobe = 1'b0;
        hold(4);
        for (int i = 0; i < nbits; i++) begin
            ctl_sdat = w[i];
            hold(4);
            ctl_sclk = 1'b1;
            hold(4);
            ctl_sclk = 1'b0;
        end
        hold(4);
        if (do_strobe) begin
            ctl_strobe = 1'b1;
            hold(8);
        end
    endtask

    initial begin
        #1_500_000ns;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        hold(5);
        // R1 reset state
        check("R1", 24'h0);
        rst_n = 1'b1;
        hold(4);
        check("R1", 24'h0);

        // R2 bit order: only bit 0 set gives level 1, only bit 11 gives 0x800
        shift_word(16'h0001, 13, 1'b1);
        exp_st = model(exp_st, 13'h0001);
        check("R2", exp_st);
        shift_word(16'h0800, 13, 1'b1);
        exp_st = model(exp_st, 13'h0800);
        check("R2", exp_st);

        // R3 level word
        shift_word(16'h0ABC, 13, 1'b1);
        exp_st = model(exp_st, 13'h0ABC);
        check("R3", exp_st);

        // R4 format bank, low bits set to show they are ignored
        shift_word({3'b0, 2'b10, 6'b101011, 5'b11111}, 13, 1'b1);
        exp_st = model(exp_st, {2'b10, 6'b101011, 5'b11111});
        check("R4", exp_st);

        // R5 boost bank
        shift_word({3'b0, 2'b11, 6'b110101, 5'b00000}, 13, 1'b1);
        exp_st = model(exp_st, {2'b11, 6'b110101, 5'b00000});
        check("R5", exp_st);

        // R6 full word shifted but not yet strobed: no change
        shift_word(16'h0123, 13, 1'b0);
        check("R6", exp_st);
        ctl_strobe = 1'b1;
        hold(8);
        exp_st = model(exp_st, 13'h0123);
        check("R6", exp_st);

        // R7 short and long words are dropped, then a good word commits
        shift_word(16'h0FFF, 12, 1'b1);
        check("R7", exp_st);
        shift_word(16'h3FFF, 14, 1'b1);
        check("R7", exp_st);
        shift_word(16'h0555, 13, 1'b1);
        exp_st = model(exp_st, 13'h0555);
        check("R7", exp_st);

        // Random mix of banks and lengths
        for (int k = 0; k < 60; k++) begin
            logic [15:0] w = 16'($urandom());
            int len = 13;
            int pick = $urandom_range(0, 7);
            if (pick == 0) len = 12;
            else if (pick == 1) len = 14;
            shift_word(w, len, 1'b1);
            if (len == 13) begin
                exp_st = model(exp_st, w[12:0]);
                check(w[12] ? (w[11] ? "R5" : "R4") : "R3", exp_st);
            end else begin
                check("R7", exp_st);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule